// File: doc/BRIEF.md
# Chainable Serial Stereo Level Port

This block is a three-wire serial control port that holds a pair of 8-bit level codes, one for the right channel and one for the left. A host lowers the active-low select, clocks bits in on the rising edge of the serial clock, and raises select again. On that rising edge the collected word moves into a parallel holding register. The holding register drives the two code outputs, and a one-cycle update strobe is raised on the system clock.

While a new word is being shifted in, the word that was in the shift register comes out on the serial data output, most significant bit first, and that output changes on falling clock edges. The output floats whenever select is high. Because the output replays the old word, units can be wired output-to-input: the host holds select low for 16 clocks per unit, and every unit loads its own word on the same select rising edge. All serial inputs are synchronised into the system clock domain. Their edges are found there, so the serial clock has to run well below the system clock.

Top module: `vsp_gain_port`

## Requirements
- R1: Reset clears the holding register (both codes read 0) and the shift register, so the first frame after reset streams out sixteen 0 bits.
- R2: The word is received most significant bit first, and the first 8 bits received form the right-channel code (holding bits 15:8).
- R3: The last 8 bits received form the left-channel code (holding bits 7:0).
- R4: Serial data is sampled only on a rising serial clock edge while select is low; clock edges and data while select is high leave the shift register unchanged.
- R5: The serial output presents the earlier shift register contents, most significant bit first. The first bit appears when select falls, and each further bit follows a falling serial clock edge.
- R6: The serial output is high impedance whenever select is high, including right after reset.
- R7: The codes change only on a select rising edge; they keep the old word during a frame.
- R8: On a frame of any length the holding register takes the last 16 bits shifted in. After k<16 clocks it holds the old bits 15-k..0 followed by the k new bits. No error is flagged.
- R9: Every transfer raises update for exactly one system clock cycle, in the cycle the codes change.
- R10: With two units chained and 32 clocks under one select, the downstream unit takes the first 16 bits and the upstream unit takes the last 16, and both update on the same select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high impedance while select is high |
| right_code | output | 8 | Right-channel level code |
| left_code | output | 8 | Left-channel level code |
| update | output | 1 | One-cycle strobe on each transfer |

## Verification
Full 16-bit frames use words with different upper and lower bytes, words with all-ones and all-zeros halves, and words with only the end bits set. These separate the right byte from the left byte and catch bit reversal. Each frame also checks the streamed-out bits against the word that came before, which tests the replay path and the clearing by reset. Short and long frames, and clocks given while select is high, show the last-16-bits rule and show that the shift register ignores idle clocks. A two-unit chain with 32 clocks shows that the words pass through the first unit into the second.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic [1:0] {
    SIG_CS   = 2'd0,
    SIG_SCLK = 2'd1,
    SIG_SDI  = 2'd2
  } sig_idx_e;
endpackage

// File: rtl/vsp_rst_sync.sv
module vsp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/vsp_in_sync.sv
module vsp_in_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{INIT[i]}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d[i]};
    end
    assign q[i] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/vsp_edge.sv
module vsp_edge #(
  parameter int unsigned N     = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= INIT;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign rise[i] = lvl[i] & ~prev_q[i];
    assign fall[i] = ~lvl[i] & prev_q[i];
  end
endmodule

// File: rtl/vsp_shifter.sv
module vsp_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_lvl,
  input  logic         cs_fall,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         sdi_lvl,
  output logic [W-1:0] shreg,
  output logic         out_bit
);
  logic [W-1:0] sh_d, sh_q;
  logic         ob_d, ob_q;
  logic         shift_en, out_en;

  assign shift_en = ~cs_lvl & sclk_rise;
  assign out_en   = cs_fall | (~cs_lvl & sclk_fall);

  always_comb begin
    sh_d = sh_q;
    ob_d = ob_q;
    if (shift_en) sh_d = {sh_q[W-2:0], sdi_lvl};
    if (out_en)   ob_d = sh_q[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      ob_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      ob_q <= ob_d;
    end
  end

  assign shreg   = sh_q;
  assign out_bit = ob_q;
endmodule

// File: rtl/vsp_hold.sv
module vsp_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] hold,
  output logic         strobe
);
  logic [W-1:0] hold_d, hold_q;
  logic         stb_d, stb_q;

  always_comb begin
    hold_d = hold_q;
    stb_d  = load;
    if (load) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      stb_q  <= stb_d;
    end
  end

  assign hold   = hold_q;
  assign strobe = stb_q;
endmodule

// File: rtl/vsp_gain_port.sv
module vsp_gain_port
  import vsp_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [CODE_W-1:0] right_code,
  output logic [CODE_W-1:0] left_code,
  output logic              update
);
  localparam int unsigned WORD_W = 2 * CODE_W;

  logic              rst_sn;
  logic [2:0]        raw_in, syn_in;
  logic [1:0]        rise, fall;
  logic              cs_lvl, sclk_lvl, sdi_lvl;
  logic [WORD_W-1:0] shreg, hold;
  logic              out_bit;

  vsp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  always_comb begin
    raw_in           = '0;
    raw_in[SIG_CS]   = cs_n;
    raw_in[SIG_SCLK] = sclk;
    raw_in[SIG_SDI]  = sdi;
  end

  vsp_in_sync #(.N(3), .STAGES(SYNC_STAGES), .INIT(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d(raw_in), .q(syn_in)
  );

  assign cs_lvl   = syn_in[SIG_CS];
  assign sclk_lvl = syn_in[SIG_SCLK];
  assign sdi_lvl  = syn_in[SIG_SDI];

  vsp_edge #(.N(2), .INIT(2'b01)) u_edge (
    .clk(clk), .rst_n(rst_sn), .lvl({sclk_lvl, cs_lvl}), .rise(rise), .fall(fall)
  );

  vsp_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_sn), .cs_lvl(cs_lvl), .cs_fall(fall[0]),
    .sclk_rise(rise[1]), .sclk_fall(fall[1]), .sdi_lvl(sdi_lvl),
    .shreg(shreg), .out_bit(out_bit)
  );

  vsp_hold #(.W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_sn), .load(rise[0]), .din(shreg),
    .hold(hold), .strobe(update)
  );

  assign right_code = hold[WORD_W-1:CODE_W];
  assign left_code  = hold[CODE_W-1:0];
  assign sdo        = cs_lvl ? 1'bz : out_bit;
endmodule

// File: rtl/vsp_gain_port_chk.sv
module vsp_gain_port_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_lvl,
  input logic         sclk_rise,
  input logic         sclk_fall,
  input logic         sdi_lvl,
  input logic [W-1:0] shreg,
  input logic [W-1:0] codes,
  input logic         out_bit,
  input logic         update
);
  // R9
  update_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update |-> $stable(codes));

  // R8
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> (codes == $past(shreg)));

  // R4
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> $stable(shreg));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && sclk_rise) |=> (shreg == {$past(shreg[W-2:0]), $past(sdi_lvl)}));

  // R5
  replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && sclk_fall) |=> (out_bit == $past(shreg[W-1])));
endmodule

bind vsp_gain_port vsp_gain_port_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .cs_lvl(cs_lvl), .sclk_rise(rise[1]),
  .sclk_fall(fall[1]), .sdi_lvl(sdi_lvl), .shreg(shreg), .codes(hold),
  .out_bit(out_bit), .update(update)
);

// File: tb/vsp_gain_port_tb.sv
`timescale 1ns/1ps
module vsp_gain_port_tb;
  localparam int H = 8;
  localparam int NV = 6;
  // {word, expected right, expected left}
  localparam logic [31:0] VEC [NV] = '{
    32'hA55A_A5_5A, 32'hFF00_FF_00, 32'h00FF_00_FF,
    32'h8001_80_01, 32'h1234_12_34, 32'h0000_00_00
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi;
  wire  sdo, sdo2, chain_in;
  logic [7:0] right_code, left_code, right2, left2;
  logic update, update2;
  int checks = 0, errors = 0;
  int upd_cnt = 0, run = 0, max_run = 0;
  logic [63:0] cap;
  logic [15:0] mid_codes, prev;

  always #5 clk = ~clk;

  assign chain_in = (sdo === 1'bz) ? 1'b0 : sdo;

  vsp_gain_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .right_code(right_code), .left_code(left_code), .update(update)
  );

  vsp_gain_port u_dut2 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(chain_in), .sdo(sdo2),
    .right_code(right2), .left_code(left2), .update(update2)
  );

  always @(negedge clk) begin
    if (update) begin
      upd_cnt++; run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic frame(input int n, input logic [63:0] bits);
    cap = '0;
    cs_n = 1'b0;
    waitc(H);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      waitc(H);
      cap = {cap[62:0], sdo};
      if (i == 8) mid_codes = {right_code, left_code};
      sclk = 1'b1;
      waitc(H);
      sclk = 1'b0;
    end
    waitc(H);
    cs_n = 1'b1;
    waitc(2 * H);
  endtask

  initial begin
    waitc(100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    waitc(5);
    rst_n = 1'b1;
    waitc(6);
    // R1 R6: reset state
    chk("R1 codes after reset", {right_code, left_code}, 16'h0000);
    chk("R9 no strobe after reset", update, 1'b0);
    chk("R6 sdo floats after reset", (sdo === 1'bz), 1'b1);

    prev = 16'h0000;
    for (int k = 0; k < NV; k++) begin
      base = upd_cnt;
      frame(16, VEC[k][31:16]);
      chk("R5 replay of previous word (R1 on first)", cap[15:0], prev);
      chk("R7 codes held mid-frame", mid_codes, prev);
      chk("R2 right code", right_code, VEC[k][15:8]);
      chk("R3 left code", left_code, VEC[k][7:0]);
      chk("R9 one strobe per transfer", upd_cnt - base, 1);
      chk("R6 sdo floats after frame", (sdo === 1'bz), 1'b1);
      prev = VEC[k][31:16];
    end

    // R4: clocks with select high are ignored
    prev = 16'hC3E1;
    frame(16, prev);
    for (int i = 0; i < 10; i++) begin
      sdi = i[0]; sclk = 1'b1; waitc(H); sclk = 1'b0; waitc(H);
    end
    chk("R4 codes unchanged by idle clocks", {right_code, left_code}, prev);
    chk("R6 sdo floats with idle clocks", (sdo === 1'bz), 1'b1);
    base = upd_cnt;
    frame(4, 64'hB);
    chk("R4 shift register untouched by idle clocks", cap[3:0], prev[15:12]);
    chk("R8 short frame keeps old low bits", {right_code, left_code}, {prev[11:0], 4'hB});
    chk("R9 strobe on short frame", upd_cnt - base, 1);
    prev = {prev[11:0], 4'hB};

    // R8: long frame keeps the last 16 bits
    frame(20, 64'hC3A5F);
    chk("R8 long frame takes last 16 bits", {right_code, left_code}, 16'h3A5F);
    chk("R5 long frame stream", cap[19:0], {prev, 4'hC});
    chk("R9 strobe width one cycle", max_run, 1);

    // R10: two units chained
    base = upd_cnt;
    frame(32, {32'h0, 16'h5E71, 16'h9AC4});
    chk("R10 upstream unit word", {right_code, left_code}, 16'h9AC4);
    chk("R10 downstream unit word", {right2, left2}, 16'h5E71);
    chk("R10 single update for chain", upd_cnt - base, 1);

    // R1: reset during operation clears both registers
    rst_n = 1'b0;
    waitc(3);
    chk("R1 codes cleared by reset", {right_code, left_code}, 16'h0000);
    rst_n = 1'b1;
    waitc(6);
    frame(16, 16'h1111);
    chk("R1 shift register cleared by reset", cap[15:0], 16'h0000);
    chk("R2 word after reset", {right_code, left_code}, 16'h1111);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule